// File: doc/BRIEF.md
# Variable-Page Translation Buffer with Pinned Slots

This block is a small, fully associative address translation cache. Every entry holds an inclusive virtual range, given by a start and an end address, and the physical address that the start maps to. A lookup port is purely combinational. In the same cycle it returns whether the probed virtual address falls inside a valid entry, which entry matched, and the translated physical address. The translated address is the entry's physical base plus the offset of the probe from the entry's start.

The lowest `N_PIN` entries are pinned slots that software places explicitly, with a start page, a length in pages and a slot number. The remaining entries are ordinary and come in power-of-four page sizes. An ordinary insert first removes every ordinary entry that overlaps its range. It then takes the lowest-numbered free ordinary entry. When no ordinary entry is free, a rotating pointer picks the victim. Range purges and the purge-all command touch only ordinary entries. Pinned slots are removed only by the dedicated slot purge.

Commands arrive one per cycle on a valid/ready interface, and each one completes in the cycle it is accepted. A one-cycle error pulse follows any command that is rejected.

Top module: `vpt_tlb`

## Requirements
- R1: When the probe address lies in the range [start, end] of a valid entry, `lk_hit` is 1, `lk_idx` names that entry, and `lk_pa` equals the entry's physical base plus (probe − start), truncated to `PA_W` bits. With no such entry, `lk_hit` is 0.
- R2: When several valid entries contain the probe, the lowest index wins, so pinned slots take priority over ordinary entries.
- R3: An insert command (`cmd_op`=0) with size code n (`cmd_size`) covers 2^(`PAGE_BITS`+2n) bytes, saturating at the whole address space. The start is `cmd_addr` aligned down to that size. The physical base is `cmd_ppn`<<`PAGE_BITS`, aligned down to the same size and truncated to `PA_W` bits.
- R4: Before an insert writes its entry, every valid ordinary entry whose range overlaps the new range is invalidated.
- R5: A range purge (`cmd_op`=1) starts at `cmd_addr` with its page-offset bits cleared. It spans 2^(`PAGE_BITS`+2c) bytes, where c is `cmd_addr[3:0]`, and the end saturates at the top of the address space. A code of 0 purges one page. Every valid ordinary entry that overlaps this range is invalidated.
- R6: Range purges and purge-all never change a pinned slot.
- R7: An insert uses the lowest-index ordinary entry that is free once the overlap invalidation has taken effect.
- R8: When no ordinary entry is free, the victim is a rotating pointer that runs over indices `N_PIN`..`N_ENT`−1, wraps back to `N_PIN`, and starts at `N_PIN` after reset. The pointer advances only when it is used.
- R9: Purge-all (`cmd_op`=2) invalidates every ordinary entry and resets the rotating pointer to `N_PIN`.
- R10: A pinned insert (`cmd_op`=3) loads slot `cmd_slot`. Its start is `cmd_addr` page-aligned, its end is start + `cmd_len`·page − 1 saturated, and its base is `cmd_ppn`<<`PAGE_BITS`. A slot ≥ `N_PIN` or a length of 0 raises `cmd_err` in the next cycle and changes nothing.
- R11: A pinned purge (`cmd_op`=4) invalidates slot `cmd_slot`. A slot ≥ `N_PIN` raises `cmd_err` in the next cycle and changes nothing.
- R12: Op codes 5 to 7 raise `cmd_err` and change nothing. Accepted ops 0 to 2, and valid ops 3 and 4, leave `cmd_err` low.
- R13: After reset no address hits, `cmd_err` is 0, and `cmd_ready` is 1 from the first clock after reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_op | input | 3 | Command code (0 insert, 1 range purge, 2 purge-all, 3 pinned insert, 4 pinned purge) |
| cmd_addr | input | VA_W | Virtual address; for a range purge, bits [3:0] hold the size code |
| cmd_ppn | input | PA_W-PAGE_BITS | Physical page number |
| cmd_size | input | 4 | Size code of an ordinary insert |
| cmd_len | input | LEN_W | Pinned-insert length in pages |
| cmd_slot | input | $clog2(N_ENT) | Pinned slot number |
| cmd_err | output | 1 | Rejected-command pulse, one cycle after acceptance |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | $clog2(N_ENT) | Index of the winning entry |
| lk_pa | output | PA_W | Translated physical address |

## Verification
The hardest state to reach is the one where the rotating pointer matters. That takes a full set of ordinary entries and a pointer that has already moved before a purge-all resets it. The stimulus fills every ordinary entry with disjoint pages and inserts past capacity, so the pointer walks away from its start. After a purge-all it refills the table and checks that the first replacement lands back on the lowest ordinary index. Overlaps between pinned slots and ordinary entries, and purge ranges that saturate at the top of the space, come from sweeping every size code with a reference table kept in the bench and probing each entry's edges.

// File: rtl/vpt_tlb_pkg.sv
package vpt_tlb_pkg;
   typedef enum logic [2:0] {
      OP_INSERT    = 3'd0,
      OP_PURGE     = 3'd1,
      OP_FLUSH_ALL = 3'd2,
      OP_PIN_SET   = 3'd3,
      OP_PIN_CLR   = 3'd4
   } tlb_op_e;

   localparam int unsigned OP_LAST = 4;
endpackage

// File: rtl/vpt_tlb_cmp.sv
module vpt_tlb_cmp #(
   parameter int VA_W = 32
) (
   input  logic            ent_ok,
   input  logic [VA_W-1:0] ent_lo,
   input  logic [VA_W-1:0] ent_hi,
   input  logic [VA_W-1:0] probe,
   input  logic [VA_W-1:0] rng_lo,
   input  logic [VA_W-1:0] rng_hi,
   output logic            hit,
   output logic            ovl
);
   assign hit = ent_ok && (probe >= ent_lo) && (probe <= ent_hi);
   assign ovl = ent_ok && (ent_lo <= rng_hi) && (ent_hi >= rng_lo);
endmodule

// File: rtl/vpt_tlb_victim.sv
module vpt_tlb_victim #(
   parameter int N_ENT = 8,
   parameter int N_PIN = 2,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_ENT-1:0] free_vec,
   input  logic             alloc,
   input  logic             restart,
   output logic [IDX_W-1:0] victim
);
   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] low_free;
   logic             any_free;

   always_comb begin
      low_free = '0;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (free_vec[i]) low_free = IDX_W'(i);
      end
   end

   assign any_free = |free_vec;
   assign victim   = any_free ? low_free : rr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= IDX_W'(N_PIN);
      end else if (restart) begin
         rr_q <= IDX_W'(N_PIN);
      end else if (alloc && !any_free) begin
         rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? IDX_W'(N_PIN) : rr_q + 1'b1;
      end
   end
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
   import vpt_tlb_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 28,
   parameter int PAGE_BITS = 12,
   parameter int N_ENT     = 8,
   parameter int N_PIN     = 2,
   parameter int LEN_W     = 16,
   localparam int IDX_W    = $clog2(N_ENT),
   localparam int PPN_W    = PA_W - PAGE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [2:0]       cmd_op,
   input  logic [VA_W-1:0]  cmd_addr,
   input  logic [PPN_W-1:0] cmd_ppn,
   input  logic [3:0]       cmd_size,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic [IDX_W-1:0] cmd_slot,
   output logic             cmd_err,
   input  logic [VA_W-1:0]  lk_va,
   output logic             lk_hit,
   output logic [IDX_W-1:0] lk_idx,
   output logic [PA_W-1:0]  lk_pa
);
   localparam int WW = VA_W + LEN_W + 1;

   if (N_PIN < 1 || N_PIN >= N_ENT) begin : g_bad_pin
      $error("vpt_tlb: N_PIN must lie in 1..N_ENT-1");
   end
   if (PAGE_BITS < 4 || PA_W <= PAGE_BITS || VA_W <= PAGE_BITS) begin : g_bad_width
      $error("vpt_tlb: page size or address widths out of range");
   end

   function automatic logic [VA_W-1:0] va_span(input logic [3:0] code);
      int sh;
      sh = PAGE_BITS + 2 * int'(code);
      return ~({VA_W{1'b1}} << sh);
   endfunction

   function automatic logic [PA_W-1:0] pa_span(input logic [3:0] code);
      int sh;
      sh = PAGE_BITS + 2 * int'(code);
      return ~({PA_W{1'b1}} << sh);
   endfunction

   // Entry storage
   logic            ent_ok [N_ENT];
   logic [VA_W-1:0] ent_lo [N_ENT];
   logic [VA_W-1:0] ent_hi [N_ENT];
   logic [PA_W-1:0] ent_pa [N_ENT];
   logic [N_ENT-1:0] valid_vec, hit_vec, ovl_vec, free_vec;

   // Command decode
   tlb_op_e op;
   logic    fire, do_ins, do_pur, do_all, slot_ok, pin_set_ok, pin_clr_ok, bad_cmd;
   assign op         = tlb_op_e'(cmd_op);
   assign fire       = cmd_valid && cmd_ready;
   assign do_ins     = fire && (op == OP_INSERT);
   assign do_pur     = fire && (op == OP_PURGE);
   assign do_all     = fire && (op == OP_FLUSH_ALL);
   assign slot_ok    = int'(cmd_slot) < N_PIN;
   assign pin_set_ok = fire && (op == OP_PIN_SET) && slot_ok && (cmd_len != '0);
   assign pin_clr_ok = fire && (op == OP_PIN_CLR) && slot_ok;
   assign bad_cmd    = fire && (((op == OP_PIN_SET) && !(slot_ok && (cmd_len != '0))) ||
                                ((op == OP_PIN_CLR) && !slot_ok) ||
                                (int'(cmd_op) > int'(OP_LAST)));

   // Range arithmetic
   logic [VA_W-1:0] ins_mask, ins_lo, ins_hi, pg_lo, pg_mask, pg_hi, pin_hi, rng_lo, rng_hi;
   logic [PA_W-1:0] ins_pa, pin_pa;
   logic [VA_W:0]   pg_sum;
   logic [WW-1:0]   pin_sum;

   assign ins_mask = va_span(cmd_size);
   assign ins_lo   = cmd_addr & ~ins_mask;
   assign ins_hi   = ins_lo | ins_mask;
   assign pin_pa   = {cmd_ppn, {PAGE_BITS{1'b0}}};
   assign ins_pa   = pin_pa & ~pa_span(cmd_size);

   assign pg_lo    = {cmd_addr[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
   assign pg_mask  = va_span(cmd_addr[3:0]);
   assign pg_sum   = {1'b0, pg_lo} + {1'b0, pg_mask};
   assign pg_hi    = pg_sum[VA_W] ? {VA_W{1'b1}} : pg_sum[VA_W-1:0];

   assign pin_sum  = WW'(pg_lo) + (WW'(cmd_len) << PAGE_BITS) - WW'(1);
   assign pin_hi   = (|pin_sum[WW-1:VA_W]) ? {VA_W{1'b1}} : pin_sum[VA_W-1:0];

   assign rng_lo   = (op == OP_INSERT) ? ins_lo : pg_lo;
   assign rng_hi   = (op == OP_INSERT) ? ins_hi : pg_hi;

   // Per-entry compare and state
   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      vpt_tlb_cmp #(.VA_W(VA_W)) u_cmp (
         .ent_ok (ent_ok[i]),
         .ent_lo (ent_lo[i]),
         .ent_hi (ent_hi[i]),
         .probe  (lk_va),
         .rng_lo (rng_lo),
         .rng_hi (rng_hi),
         .hit    (hit_vec[i]),
         .ovl    (ovl_vec[i])
      );
      assign valid_vec[i] = ent_ok[i];

      if (i < N_PIN) begin : g_pin
         assign free_vec[i] = 1'b0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent_ok[i] <= 1'b0;
               ent_lo[i] <= '0;
               ent_hi[i] <= '0;
               ent_pa[i] <= '0;
            end else if (pin_set_ok && cmd_slot == IDX_W'(i)) begin
               ent_ok[i] <= 1'b1;
               ent_lo[i] <= pg_lo;
               ent_hi[i] <= pin_hi;
               ent_pa[i] <= pin_pa;
            end else if (pin_clr_ok && cmd_slot == IDX_W'(i)) begin
               ent_ok[i] <= 1'b0;
            end
         end
      end else begin : g_ord
         assign free_vec[i] = !ent_ok[i] || ovl_vec[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent_ok[i] <= 1'b0;
               ent_lo[i] <= '0;
               ent_hi[i] <= '0;
               ent_pa[i] <= '0;
            end else if (do_all) begin
               ent_ok[i] <= 1'b0;
            end else if (do_ins && vic_idx == IDX_W'(i)) begin
               ent_ok[i] <= 1'b1;
               ent_lo[i] <= ins_lo;
               ent_hi[i] <= ins_hi;
               ent_pa[i] <= ins_pa;
            end else if ((do_ins || do_pur) && ovl_vec[i]) begin
               ent_ok[i] <= 1'b0;
            end
         end
      end
   end

   logic [IDX_W-1:0] vic_idx;
   vpt_tlb_victim #(.N_ENT(N_ENT), .N_PIN(N_PIN)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .free_vec (free_vec),
      .alloc    (do_ins),
      .restart  (do_all),
      .victim   (vic_idx)
   );

   // Lookup: lowest matching index wins
   logic [IDX_W-1:0] sel;
   always_comb begin
      sel = '0;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (hit_vec[i]) sel = IDX_W'(i);
      end
   end
   assign lk_hit = |hit_vec;
   assign lk_idx = sel;
   assign lk_pa  = ent_pa[sel] + PA_W'(lk_va - ent_lo[sel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_ready <= 1'b0;
         cmd_err   <= 1'b0;
      end else begin
         cmd_ready <= 1'b1;
         cmd_err   <= bad_cmd;
      end
   end
endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk #(
   parameter int N_ENT = 8,
   parameter int N_PIN = 2,
   parameter int LEN_W = 16,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [2:0]       cmd_op,
   input logic [LEN_W-1:0] cmd_len,
   input logic [IDX_W-1:0] cmd_slot,
   input logic             cmd_err,
   input logic             lk_hit,
   input logic [IDX_W-1:0] lk_idx,
   input logic [N_ENT-1:0] valid_vec
);
   logic fire;
   assign fire = cmd_valid && cmd_ready;

   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> valid_vec[lk_idx]); // R1
   AST_PIN_KEPT_ON_PURGE: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (cmd_op == 3'd1 || cmd_op == 3'd2) |=> valid_vec[N_PIN-1:0] == $past(valid_vec[N_PIN-1:0])); // R6
   AST_FLUSH_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cmd_op == 3'd2 |=> valid_vec[N_ENT-1:N_PIN] == '0); // R9
   AST_INSERT_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cmd_op == 3'd0 |=> |valid_vec[N_ENT-1:N_PIN]); // R7
   AST_PIN_SET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cmd_op == 3'd3 && cmd_slot < IDX_W'(N_PIN) && cmd_len != '0 |=> valid_vec[$past(cmd_slot)] && !cmd_err); // R10
   AST_PIN_CLR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cmd_op == 3'd4 && cmd_slot >= IDX_W'(N_PIN) |=> cmd_err && $stable(valid_vec)); // R11
   AST_BAD_OP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cmd_op > 3'd4 |=> cmd_err && $stable(valid_vec)); // R12
   AST_ORD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cmd_op <= 3'd2 |=> !cmd_err); // R12
endmodule

bind vpt_tlb vpt_tlb_chk #(.N_ENT(N_ENT), .N_PIN(N_PIN), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .cmd_len   (cmd_len),
   .cmd_slot  (cmd_slot),
   .cmd_err   (cmd_err),
   .lk_hit    (lk_hit),
   .lk_idx    (lk_idx),
   .valid_vec (valid_vec)
);

// File: tb/vpt_tlb_test.sv
module vpt_tlb_test;
   localparam int VA_W = 32, PA_W = 28, PB = 12, NE = 8, NP = 2, LW = 16;
   localparam int IW = $clog2(NE);
   localparam longint VMAX = (64'd1 << VA_W) - 1;
   localparam longint PMAX = (64'd1 << PA_W) - 1;
   localparam longint PGM  = (64'd1 << PB) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_ready, cmd_err, lk_hit;
   logic [2:0] cmd_op = '0;
   logic [VA_W-1:0] cmd_addr = '0, lk_va = '0;
   logic [PA_W-PB-1:0] cmd_ppn = '0;
   logic [3:0] cmd_size = '0;
   logic [LW-1:0] cmd_len = '0;
   logic [IW-1:0] cmd_slot = '0, lk_idx;
   logic [PA_W-1:0] lk_pa;

   int nchk = 0, nfail = 0;
   bit done = 0;

   bit     mv  [NE];
   longint mlo [NE], mhi [NE], mpa [NE];
   int     mrr;

   always #5 clk = ~clk;

   vpt_tlb #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PB), .N_ENT(NE), .N_PIN(NP), .LEN_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_ppn(cmd_ppn), .cmd_size(cmd_size), .cmd_len(cmd_len),
      .cmd_slot(cmd_slot), .cmd_err(cmd_err), .lk_va(lk_va), .lk_hit(lk_hit),
      .lk_idx(lk_idx), .lk_pa(lk_pa));

   function automatic longint vspan(int code);
      int sh = PB + 2 * code;
      return (sh >= VA_W) ? VMAX : ((64'd1 << sh) - 1);
   endfunction
   function automatic longint pspan(int code);
      int sh = PB + 2 * code;
      return (sh >= PA_W) ? PMAX : ((64'd1 << sh) - 1);
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_ord(longint lo, longint hi);
      for (int i = NP; i < NE; i++)
         if (mv[i] && mlo[i] <= hi && mhi[i] >= lo) mv[i] = 0;
   endtask

   task automatic model_cmd(int op, longint addr, longint ppn, int size, int len, int slot, output bit err);
      longint lo, hi, m;
      int v;
      err = 0;
      case (op)
         0: begin
            m = vspan(size); lo = addr & ~m & VMAX; hi = lo | m;
            clear_ord(lo, hi);
            v = -1;
            for (int i = NP; i < NE; i++) if (!mv[i] && v < 0) v = i;
            if (v < 0) begin v = mrr; mrr = (mrr == NE - 1) ? NP : mrr + 1; end
            mv[v] = 1; mlo[v] = lo; mhi[v] = hi;
            mpa[v] = (ppn << PB) & ~pspan(size) & PMAX;
         end
         1: begin
            lo = addr & ~PGM & VMAX; hi = lo + vspan(int'(addr & 15));
            if (hi > VMAX) hi = VMAX;
            clear_ord(lo, hi);
         end
         2: begin
            for (int i = NP; i < NE; i++) mv[i] = 0;
            mrr = NP;
         end
         3: begin
            if (slot < NP && len != 0) begin
               lo = addr & ~PGM & VMAX; hi = lo + longint'(len) * (PGM + 1) - 1;
               if (hi > VMAX) hi = VMAX;
               mv[slot] = 1; mlo[slot] = lo; mhi[slot] = hi; mpa[slot] = (ppn << PB) & PMAX;
            end else err = 1;
         end
         4: begin
            if (slot < NP) mv[slot] = 0; else err = 1;
         end
         default: err = 1;
      endcase
   endtask

   task automatic probe(longint va, string req);
      int w = -1;
      lk_va = VA_W'(va);
      #1;
      for (int i = NE - 1; i >= 0; i--) if (mv[i] && va >= mlo[i] && va <= mhi[i]) w = i;
      chk(lk_hit == (w >= 0), req, "hit", longint'(lk_hit), longint'(w >= 0));
      if (w >= 0 && lk_hit) begin
         chk(int'(lk_idx) == w, req, "idx", longint'(lk_idx), longint'(w));
         chk(longint'(lk_pa) == ((mpa[w] + (va - mlo[w])) & PMAX), req, "pa",
             longint'(lk_pa), (mpa[w] + (va - mlo[w])) & PMAX);
      end
   endtask

   task automatic probe_all(string req);
      for (int i = 0; i < NE; i++) if (mv[i]) begin
         probe(mlo[i], req); probe(mhi[i], req); probe((mlo[i] + mhi[i]) / 2, req);
         if (mlo[i] > 0) probe(mlo[i] - 1, req);
         if (mhi[i] < VMAX) probe(mhi[i] + 1, req);
      end
      probe(0, req); probe(VMAX, req);
   endtask

   task automatic do_cmd(int op, longint addr, longint ppn, int size, int len, int slot, string req);
      bit eerr;
      @(negedge clk);
      cmd_op = 3'(op); cmd_addr = VA_W'(addr); cmd_ppn = (PA_W-PB)'(ppn);
      cmd_size = 4'(size); cmd_len = LW'(len); cmd_slot = IW'(slot); cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      model_cmd(op, addr, ppn, size, len, slot, eerr);
      chk(cmd_err == eerr, req, "cmd_err", longint'(cmd_err), longint'(eerr));
      probe_all(req);
   endtask

   task automatic expect_at(longint va, bit h, int idx, longint pa, string req);
      lk_va = VA_W'(va);
      #1;
      chk(lk_hit == h, req, "directed hit", longint'(lk_hit), longint'(h));
      if (h) begin
         chk(int'(lk_idx) == idx, req, "directed idx", longint'(lk_idx), longint'(idx));
         chk(longint'(lk_pa) == pa, req, "directed pa", longint'(lk_pa), pa);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NE; i++) begin mv[i] = 0; mlo[i] = 0; mhi[i] = 0; mpa[i] = 0; end
      mrr = NP;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13: reset state
      chk(cmd_ready == 1'b1, "R13", "ready", longint'(cmd_ready), 1);
      chk(cmd_err == 1'b0, "R13", "err", longint'(cmd_err), 0);
      probe(32'h0001_2345, "R13"); probe(0, "R13"); probe(VMAX, "R13");

      // R3 sizes and alignment
      do_cmd(0, 32'h0001_2345, 'h345, 0, 0, 0, "R3");
      expect_at(32'h0001_2abc, 1, 2, 'h345abc, "R3");
      do_cmd(0, 32'h0040_5000, 'h1237, 2, 0, 0, "R3");
      expect_at(32'h0040_fffe, 1, 3, 'h123fffe, "R3");
      expect_at(32'h0041_0000, 0, 0, 0, "R1");
      // R4 overlap invalidation
      do_cmd(0, 32'h0040_1000, 'h55, 0, 0, 0, "R4");
      expect_at(32'h0040_5000, 0, 0, 0, "R4");
      expect_at(32'h0040_1010, 1, 3, 'h55010, "R4");
      // R7 lowest free entry
      for (int k = 0; k < 4; k++) begin
         do_cmd(0, 32'h0080_0000 + k * 'h1000, 'h100 + k, 0, 0, 0, "R7");
         expect_at(32'h0080_0004 + k * 'h1000, 1, 4 + k, (('h100 + k) << PB) + 4, "R7");
      end
      // R8 rotating replacement
      for (int k = 0; k < 3; k++) begin
         do_cmd(0, 32'h0090_0000 + k * 'h1000, 'h200 + k, 0, 0, 0, "R8");
         expect_at(32'h0090_0000 + k * 'h1000, 1, 2 + k, ('h200 + k) << PB, "R8");
      end
      // R10 pinned insert, R2 priority
      do_cmd(3, 32'h0080_1000, 'h7000, 0, 2, 0, "R10");
      expect_at(32'h0080_2010, 1, 0, 'h7001010, "R2");
      do_cmd(3, 32'h0010_0000, 'h1, 0, 1, 2, "R10");
      do_cmd(3, 32'h0010_0000, 'h1, 0, 0, 1, "R10");
      do_cmd(3, 32'hffff_e000, 'h10, 0, 5, 1, "R10");
      expect_at(VMAX, 1, 1, 'h11fff, "R10");
      // R6 / R5 purges
      do_cmd(1, 32'h0080_2000, 0, 0, 0, 0, "R6");
      expect_at(32'h0080_2010, 1, 0, 'h7001010, "R6");
      do_cmd(1, 32'h0090_0002, 0, 0, 0, 0, "R5");
      expect_at(32'h0090_2000, 0, 0, 0, "R5");
      // R9 purge-all and pointer restart
      do_cmd(2, 0, 0, 0, 0, 0, "R9");
      expect_at(32'h0080_2010, 1, 0, 'h7001010, "R6");
      expect_at(32'h0080_3000, 0, 0, 0, "R9");
      for (int k = 0; k < NE - NP; k++) do_cmd(0, 32'h00a0_0000 + k * 'h1000, 'h300 + k, 0, 0, 0, "R7");
      do_cmd(0, 32'h00b0_0000, 'h400, 0, 0, 0, "R9");
      expect_at(32'h00b0_0000, 1, 2, 'h400 << PB, "R9");
      // R11 pinned purge
      do_cmd(4, 0, 0, 0, 0, 0, "R11");
      expect_at(32'h0080_2010, 0, 0, 0, "R11");
      do_cmd(4, 0, 0, 0, 0, 3, "R11");
      // R12 unknown ops
      for (int op = 5; op < 8; op++) do_cmd(op, 32'h0000_5000, 'h9, 1, 1, 0, "R12");

      // Sweep insert sizes (R3) and purge codes (R5)
      for (int c = 0; c < 16; c++) begin
         do_cmd(2, 0, 0, 0, 0, 0, "R9");
         do_cmd(0, 32'h5a5a_5a5a ^ (c * 32'h0100_0000), 'h0ab_cdef ^ c, c, 0, 0, "R3");
         do_cmd(0, 32'h0000_3000, 'h42 + c, 0, 0, 0, "R3");
      end
      for (int c = 0; c < 16; c++) begin
         do_cmd(2, 0, 0, 0, 0, 0, "R9");
         do_cmd(3, 32'h0060_0000, 'h99, 0, 3, 1, "R6");
         for (int k = 0; k < NE - NP; k++)
            do_cmd(0, 32'h0060_0000 + k * (32'h0001_0000 << (2 * (k % 3))), 'h500 + k, k % 3, 0, 0, "R7");
         do_cmd(1, 32'h0060_3000 + c, 0, 0, 0, 0, "R5");
      end
      finish_run();
   end
endmodule